// File: doc/BRIEF.md
# Microcode Store Staged Loader

This block is a host-bus slave in front of a 256-entry store of 64-bit microcode words. The host cannot write a whole word in one bus cycle, so it builds each word in four 16-bit staging registers. It then writes a target entry number to a separate address register. That write copies the assembled word into the store, but only while the configuration register holds the load key.

An execution engine fetches words through a synchronous read port. A second synchronous port reads the sixteen vector entries at the top of the store, 0xF0 to 0xFF, by a 4-bit index. A small interrupt status register collects four event flags from the surrounding logic. The host reads the flags and clears them by writing ones.

Top module: `ucode_loader`

## Requirements
- R1: After reset `rst_ni` is released, reads at 0x16F0 (configuration) and 0x16F4 (interrupt status) return 0x0000, and load mode is off.
- R2: A bus write at 0x16F0 stores the low 8 bits, which read back at 0x16F0 with the upper 8 bits zero. Load mode is on exactly when the stored value is 0x03. The value changes only through a write at 0x16F0 or through reset.
- R3: Bus writes at 0x16E0, 0x16E2, 0x16E4 and 0x16E6 load staging lanes 0 to 3. With `LANE_REV`=0, lane 0 supplies word bits 63..48, lane 1 bits 47..32, lane 2 bits 31..16 and lane 3 bits 15..0.
- R4: A bus write at 0x1400 while load mode is on writes the staged word into the entry given by bits 7..0 of the written data. Bits 15..8 of the data are ignored.
- R5: A bus write at 0x1400 while load mode is off leaves every store entry unchanged.
- R6: The staging lanes keep their contents through a commit, so a second commit without new staging writes stores the same word again. Lanes change only when they are written.
- R7: `rd_data_o` presents the entry addressed by `rd_addr_i` one clock later. When a commit and a read hit the same entry in the same cycle, the read returns the old word.
- R8: `vec_data_o` presents entry 0xF0 + `vec_idx_i` one clock after the index is applied.
- R9: A high bit i of `irq_set_i` sets status bit 10+i on the next clock. A read at 0x16F4 returns the flags in bits 13..10 (mask 0x3C00), and every other bit reads as zero.
- R10: A bus write at 0x16F4 clears each flag whose bit is 1 in the data. A set input for the same flag in the same cycle wins over the clear. With no write and no set input, the flags hold.
- R11: With `LANE_REV`=1, lane 0 supplies bits 15..0, lane 1 bits 31..16, lane 2 bits 47..32 and lane 3 bits 63..48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Host write strobe, one cycle per write |
| bus_addr_i | input | 16 | Host byte offset |
| bus_wdata_i | input | 16 | Host write data |
| bus_rdata_o | output | 16 | Host read data for the offset on `bus_addr_i`, combinational |
| irq_set_i | input | 4 | Event pulses that set the interrupt flags |
| rd_addr_i | input | 8 | Fetch address |
| rd_data_o | output | 64 | Fetched word, one cycle after the address |
| vec_idx_i | input | 4 | Vector index into entries 0xF0..0xFF |
| vec_data_o | output | 64 | Vector word, one cycle after the index |

## Verification
A staging lane that is corrupt or mapped wrong shows at the next fetch of a committed entry, one clock after the read address. The affected 16-bit slice is wrong while the other three are right. A wrong load-mode state shows as an entry that changes when it must not, or stays the same when it should change, at the first fetch after the address write. Interrupt flag faults show at once on the combinational status read: a flag that does not set, does not clear, or sits outside bits 13..10.

// File: rtl/ucl_pkg.sv
package ucl_pkg;
  localparam int unsigned LANE_W    = 16;
  localparam logic [15:0] OFS_ADDR  = 16'h1400;
  localparam logic [15:0] OFS_STAGE = 16'h16E0;
  localparam logic [15:0] OFS_CFG   = 16'h16F0;
  localparam logic [15:0] OFS_IRQ   = 16'h16F4;
  localparam logic [7:0]  LOAD_KEY  = 8'h03;
  localparam int unsigned IRQ_N     = 4;
  localparam int unsigned IRQ_LSB   = 10;
endpackage

// File: rtl/ucl_stage.sv
module ucl_stage
  import ucl_pkg::*;
#(
  parameter int unsigned WORD_W   = 64,
  parameter bit          LANE_REV = 1'b0,
  localparam int unsigned LANES   = WORD_W / LANE_W,
  localparam int unsigned LSEL_W  = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [LSEL_W-1:0] lane_i,
  input  logic [LANE_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o
);
  logic [LANE_W-1:0] lane_q [LANES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < LANES; k++) lane_q[k] <= '0;
    end else if (we_i) begin
      lane_q[lane_i] <= data_i;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (LANE_REV) begin : g_rev
      assign word_o[k*LANE_W +: LANE_W] = lane_q[k];
    end else begin : g_fwd
      assign word_o[WORD_W-1-k*LANE_W -: LANE_W] = lane_q[k];
    end
  end

  AST_STAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(word_o)); // R6
endmodule

// File: rtl/ucl_store.sv
module ucl_store #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned VEC_W  = 4,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic [VEC_W-1:0]  vec_idx_i,
  output logic [WORD_W-1:0] vec_data_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [ADDR_W-1:0] vec_addr;

  // vectors occupy the top of the store
  assign vec_addr = {{(ADDR_W-VEC_W){1'b1}}, vec_idx_i};

  // read-before-write: same-entry read sees old word
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
    rd_data_o  <= mem_q[rd_addr_i];
    vec_data_o <= mem_q[vec_addr];
  end
endmodule

// File: rtl/ucl_irq.sv
module ucl_irq
  import ucl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_N-1:0] set_i,
  input  logic             clr_we_i,
  input  logic [15:0]      clr_data_i,
  output logic [15:0]      status_o
);
  logic [IRQ_N-1:0] pend_q;
  logic [IRQ_N-1:0] clr_bits;

  assign clr_bits = clr_we_i ? clr_data_i[IRQ_LSB +: IRQ_N] : '0;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_bits) | set_i;
  end

  always_comb begin
    status_o = '0;
    status_o[IRQ_LSB +: IRQ_N] = pend_q;
  end

  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i))); // R9
  AST_IRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((pend_q & $past(clr_data_i[IRQ_LSB +: IRQ_N] & ~set_i)) == '0)); // R10
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_we_i && set_i == '0) |=> $stable(pend_q)); // R10
endmodule

// File: rtl/ucode_loader.sv
module ucode_loader
  import ucl_pkg::*;
#(
  parameter int unsigned WORD_W   = 64,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned VEC_N    = 16,
  parameter bit          LANE_REV = 1'b0,
  localparam int unsigned LANES   = WORD_W / LANE_W,
  localparam int unsigned LSEL_W  = $clog2(LANES),
  localparam int unsigned VEC_W   = $clog2(VEC_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [15:0]       bus_addr_i,
  input  logic [15:0]       bus_wdata_i,
  output logic [15:0]       bus_rdata_o,
  input  logic [IRQ_N-1:0]  irq_set_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic [VEC_W-1:0]  vec_idx_i,
  output logic [WORD_W-1:0] vec_data_o
);
  logic [7:0]        cfg_q;
  logic              load_en;
  logic [15:0]       stage_off;
  logic              stage_we, cfg_we, irq_we, commit;
  logic [WORD_W-1:0] staged_word;
  logic [15:0]       irq_status;

  assign stage_off = bus_addr_i - OFS_STAGE;
  assign stage_we  = bus_we_i && (stage_off < 16'(2*LANES)) && !stage_off[0];
  assign cfg_we    = bus_we_i && (bus_addr_i == OFS_CFG);
  assign irq_we    = bus_we_i && (bus_addr_i == OFS_IRQ);
  assign load_en   = (cfg_q == LOAD_KEY);
  assign commit    = bus_we_i && (bus_addr_i == OFS_ADDR) && load_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (cfg_we) cfg_q <= bus_wdata_i[7:0];
  end

  always_comb begin
    unique case (bus_addr_i)
      OFS_CFG: bus_rdata_o = {8'h00, cfg_q};
      OFS_IRQ: bus_rdata_o = irq_status;
      default: bus_rdata_o = '0;
    endcase
  end

  ucl_stage #(.WORD_W(WORD_W), .LANE_REV(LANE_REV)) u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (stage_we),
    .lane_i (stage_off[LSEL_W:1]),
    .data_i (bus_wdata_i),
    .word_o (staged_word)
  );

  ucl_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_store (
    .clk_i      (clk_i),
    .wr_en_i    (commit),
    .wr_addr_i  (bus_wdata_i[ADDR_W-1:0]),
    .wr_data_i  (staged_word),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .vec_idx_i  (vec_idx_i),
    .vec_data_o (vec_data_o)
  );

  ucl_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (irq_set_i),
    .clr_we_i   (irq_we),
    .clr_data_i (bus_wdata_i),
    .status_o   (irq_status)
  );

  AST_CFG_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && bus_addr_i == OFS_CFG) |=> $stable(cfg_q)); // R2
  AST_IRQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == OFS_IRQ) |-> ((bus_rdata_o & 16'hC3FF) == '0)); // R9
endmodule

// File: tb/sim_ucode_loader.sv
module sim_ucode_loader;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [15:0] rdata, rdata_r;
  logic [3:0]  irq_set = '0;
  logic [7:0]  rd_addr = '0;
  logic [63:0] rd_data, rd_data_r, vec_data, vec_data_r;
  logic [3:0]  vec_idx = '0;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  ucode_loader u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_set_i(irq_set),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .vec_idx_i(vec_idx),
    .vec_data_o(vec_data)
  );

  ucode_loader #(.LANE_REV(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata_r), .irq_set_i(irq_set),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data_r), .vec_idx_i(vec_idx),
    .vec_data_o(vec_data_r)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = '0;
  endtask

  task automatic stage(input logic [63:0] w);
    bus_wr(16'h16E0, w[63:48]); bus_wr(16'h16E2, w[47:32]);
    bus_wr(16'h16E4, w[31:16]); bus_wr(16'h16E6, w[15:0]);
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic fetch(input logic [7:0] a, output logic [63:0] d, output logic [63:0] dr);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data; dr = rd_data_r;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    bus_rd(16'h16F0, v); chk("R1 cfg after reset", 64'(v), 64'h0);
    bus_rd(16'h16F4, v); chk("R1 irq after reset", 64'(v), 64'h0);
  endtask

  task automatic t_load();
    logic [15:0] v; logic [63:0] d, dr;
    bus_wr(16'h16F0, 16'hFF03);
    bus_rd(16'h16F0, v); chk("R2 cfg readback", 64'(v), 64'h03);
    stage(64'h1111_2222_3333_4444);
    bus_wr(16'h1400, 16'h0005);
    fetch(8'h05, d, dr);
    chk("R3 R4 lane map", d, 64'h1111_2222_3333_4444);
    chk("R11 reversed map", dr, 64'h4444_3333_2222_1111);
    bus_wr(16'h1400, 16'h0006);
    fetch(8'h06, d, dr); chk("R6 staging persists", d, 64'h1111_2222_3333_4444);
    bus_wr(16'h16E0, 16'hAAAA);
    bus_wr(16'h1400, 16'h3307);
    fetch(8'h07, d, dr); chk("R4 upper addr bits ignored", d, 64'hAAAA_2222_3333_4444);
    fetch(8'h06, d, dr); chk("R6 other entry untouched", d, 64'h1111_2222_3333_4444);
  endtask

  task automatic t_gate();
    logic [15:0] v; logic [63:0] d, dr;
    bus_wr(16'h16F0, 16'h0002);
    bus_rd(16'h16F0, v); chk("R2 cfg non-key", 64'(v), 64'h02);
    bus_wr(16'h16E6, 16'h9999);
    bus_wr(16'h1400, 16'h0005);
    fetch(8'h05, d, dr); chk("R5 commit ignored", d, 64'h1111_2222_3333_4444);
    bus_wr(16'h16F0, 16'h0003);
    bus_wr(16'h1400, 16'h0008);
    fetch(8'h08, d, dr); chk("R2 load re-enabled", d, 64'hAAAA_2222_3333_9999);
  endtask

  task automatic t_rw_same();
    logic [63:0] d;
    stage(64'h0123_4567_89AB_CDEF);
    @(negedge clk); we = 1'b1; addr = 16'h1400; wdata = 16'h0005; rd_addr = 8'h05;
    @(negedge clk); we = 1'b0; addr = '0; d = rd_data;
    chk("R7 same-cycle old data", d, 64'h1111_2222_3333_4444);
    @(negedge clk); d = rd_data;
    chk("R7 new data next read", d, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_vec();
    logic [63:0] d;
    stage(64'hF3F3_0000_0000_0003); bus_wr(16'h1400, 16'h00F3);
    stage(64'hF0F0_0000_0000_0000); bus_wr(16'h1400, 16'h00F0);
    @(negedge clk); vec_idx = 4'd3;
    @(negedge clk); d = vec_data; chk("R8 vector 3", d, 64'hF3F3_0000_0000_0003);
    vec_idx = 4'd0;
    @(negedge clk); d = vec_data; chk("R8 vector 0", d, 64'hF0F0_0000_0000_0000);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    @(negedge clk); irq_set = 4'b0101;
    @(negedge clk); irq_set = '0;
    bus_rd(16'h16F4, v); chk("R9 flags set", 64'(v), 64'h1400);
    bus_wr(16'h16F4, 16'h0400);
    bus_rd(16'h16F4, v); chk("R10 clear bit10", 64'(v), 64'h1000);
    bus_wr(16'h16F4, 16'hC3FF);
    bus_rd(16'h16F4, v); chk("R10 clear outside mask no effect", 64'(v), 64'h1000);
    @(negedge clk); irq_set = 4'b0010; we = 1'b1; addr = 16'h16F4; wdata = 16'h0800;
    @(negedge clk); irq_set = '0; we = 1'b0;
    bus_rd(16'h16F4, v); chk("R10 set wins over clear", 64'(v), 64'h1800);
    repeat (3) @(negedge clk);
    bus_rd(16'h16F4, v); chk("R10 flags hold", 64'(v), 64'h1800);
  endtask

  task automatic t_rereset();
    logic [63:0] d, dr;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    bus_wr(16'h1400, 16'h0008);
    fetch(8'h08, d, dr); chk("R1 R5 load off after reset", d, 64'hAAAA_2222_3333_9999);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_gate();
    t_rw_same();
    t_vec();
    t_irq();
    t_rereset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule